// File: doc/BRIEF.md
# Enhanced Parallel Port Host Bus Master

This block is the host end of an 8-bit asynchronous parallel link that uses separate address and data strobes and a peripheral wait handshake. A local command port offers three operations: address write, data write and data read. Each accepted command runs one complete bus cycle and ends with a one-cycle completion pulse. That pulse carries a timeout flag, and after a read it comes with the byte that was read. Setup time, minimum strobe width and the handshake timeout are counted in system clock cycles and set by parameters. The shared byte bus is modelled as a split output/input pair plus an output enable.

The control is one state machine with four states. IDLE goes to SETUP when a command is accepted. SETUP goes to STROBE after `SETUP_CYC` cycles. In SETUP, write-enable and, for writes, the byte are placed on the bus. STROBE goes to RELEASE once both conditions below hold:
- the strobe has been low for at least `STROBE_CYC` cycles;
- the synchronized wait input is high.

STROBE goes back to IDLE with a timeout if wait does not rise within `TIMEOUT_CYC` cycles. In RELEASE the strobe is high again. RELEASE goes to IDLE when wait returns low, or with a timeout after `TIMEOUT_CYC` cycles. All bus outputs are registered and are computed from the next state, so they change on the same edge as the state.

Top module: `epp_host_master`

## Requirements
- R1: While `rst_n` is low and after it is released: `astb_n`, `dstb_n` and `wr_n` are high, and `bus_oe`, `busy`, `done` and `timeout` are low.
- R2: The `cmd_op` codes are 0 = address write, 1 = data write and 2 = data read. A command is accepted on a clock edge where all of these hold:
  - `cmd_valid` is high;
  - the block is idle;
  - the synchronized wait is low.
  
  After acceptance, `busy` is high from the next cycle until the cycle in which `done` pulses.
- R3: The following commands are ignored, and produce no `busy`, no strobe and no `done`:
  - a command with `cmd_op` = 3;
  - a command presented while `busy` is high;
  - a command presented while the synchronized wait is high.
- R4: For writes, `wr_n` is low and `bus_oe` is high with the command byte on `bus_out`. For reads, `wr_n` is high and `bus_oe` is low. These values are present for exactly `SETUP_CYC` cycles before the strobe falls, and they are unchanged while the strobe is low.
- R5: An address write pulses only `astb_n`, and data cycles pulse only `dstb_n`. The two strobes are never low together.
- R6: A strobe stays low for at least `STROBE_CYC` cycles. If wait is already high, it is low for exactly `STROBE_CYC` cycles.
- R7: A strobe is never released before the wait input, after its `SYNC_STAGES`-flop synchronizer, has been seen high. The only exception is a timeout.
- R8: After the strobe rises, `wr_n`, `bus_oe` and `bus_out` hold their values until wait is seen low. Then `done` pulses for one cycle with `timeout` low, and `busy` is low in that cycle.
- R9: On a read, `rd_data` takes the `bus_in` byte at the edge where the strobe is released. It does not change on write cycles.
- R10: If wait does not rise within `TIMEOUT_CYC` cycles of the strobe falling, the cycle is aborted:
  - the strobe is low for exactly `TIMEOUT_CYC` cycles;
  - the strobe then returns high, the bus is released and `wr_n` goes high;
  - `done` and `timeout` pulse together.
- R11: If wait stays high for `TIMEOUT_CYC` cycles after the strobe rises, the cycle ends with `done` and `timeout` pulsing together. The bus is released and `wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 address write, 1 data write, 2 data read, 3 unused |
| cmd_wdata | input | DW | Byte for write commands |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Pulses with `done` when a handshake phase timed out |
| rd_data | output | DW | Byte returned by the last completed read |
| astb_n | output | 1 | Address strobe, active low |
| dstb_n | output | 1 | Data strobe, active low |
| wr_n | output | 1 | Low for host-to-peripheral transfers |
| bus_out | output | DW | Byte driven onto the shared bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| bus_in | input | DW | Byte seen on the shared bus |
| wait_in | input | 1 | Asynchronous peripheral wait handshake |

## Verification
The checker tests the following every cycle:
- the two strobes are never low together;
- the bus is driven only while `wr_n` is low;
- a strobe rises only after the synchronized wait was high, or together with a timeout;
- `busy` starts only on a command with wait low;
- `done` is a single pulse that ends `busy`, and `timeout` never appears without `done`.

The following depend on cycle counts and data values, so only the bench's scenarios can show them:
- the exact setup and strobe widths;
- the value captured on reads;
- hold of the byte through the release phase;
- the two timeout lengths;
- commands being ignored while busy, with an unused op code, or while wait is high.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

    typedef enum logic [1:0] {
        OP_ADDR_WR = 2'd0,
        OP_DATA_WR = 2'd1,
        OP_DATA_RD = 2'd2,
        OP_NONE    = 2'd3
    } epp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE
    } epp_state_e;

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/epp_phase_timer.sv
module epp_phase_timer #(
    parameter int LIMIT = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    // Counts cycles spent in the current phase, saturating at LIMIT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/epp_host_master.sv
module epp_host_master
    import epp_host_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SETUP_CYC   = 8,
    parameter int STROBE_CYC  = 16,
    parameter int TIMEOUT_CYC = 2_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [DW-1:0] rd_data,
    output logic          astb_n,
    output logic          dstb_n,
    output logic          wr_n,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_in,
    input  logic          wait_in
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST   = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST  = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    epp_state_e      state_q, state_d;
    epp_op_e         op_q, op_d;
    logic [DW-1:0]   byte_q, byte_d;
    logic [CNT_W-1:0] cnt;
    logic            wait_s;
    logic            accept;
    logic            abort;
    logic            is_rd_d;

    epp_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wait_in),
        .sync_out (wait_s)
    );

    epp_phase_timer #(.LIMIT(TIMEOUT_CYC), .CW(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (cnt)
    );

    assign accept = (state_q == ST_IDLE) && cmd_valid &&
                    (cmd_op != 2'd3) && !wait_s;
    assign op_d    = accept ? epp_op_e'(cmd_op) : op_q;
    assign byte_d  = accept ? cmd_wdata : byte_q;
    assign is_rd_d = (op_d == OP_DATA_RD);
    assign busy    = (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (cnt == SETUP_LAST) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if ((cnt >= STROBE_LAST) && wait_s) begin
                    state_d = ST_RELEASE;
                end else if (cnt == TIMEOUT_LAST) begin
                    state_d = ST_IDLE;
                    abort   = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!wait_s) begin
                    state_d = ST_IDLE;
                end else if (cnt == TIMEOUT_LAST) begin
                    state_d = ST_IDLE;
                    abort   = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ADDR_WR;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            byte_q  <= byte_d;
        end
    end

    // Registered outputs, derived from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            astb_n  <= 1'b1;
            dstb_n  <= 1'b1;
            wr_n    <= 1'b1;
            bus_oe  <= 1'b0;
            bus_out <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
            rd_data <= '0;
        end else begin
            done    <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            timeout <= abort;
            astb_n  <= !((state_d == ST_STROBE) && (op_d == OP_ADDR_WR));
            dstb_n  <= !((state_d == ST_STROBE) && (op_d != OP_ADDR_WR));
            wr_n    <= (state_d == ST_IDLE) || is_rd_d;
            bus_oe  <= (state_d != ST_IDLE) && !is_rd_d;
            bus_out <= byte_d;
            if ((state_q == ST_STROBE) && (state_d == ST_RELEASE) &&
                (op_q == OP_DATA_RD)) begin
                rd_data <= bus_in;
            end
        end
    end
endmodule

// File: rtl/epp_host_checker.sv
module epp_host_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic astb_n,
    input logic dstb_n,
    input logic wr_n,
    input logic bus_oe,
    input logic wait_s
);
    // R5
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!astb_n && !dstb_n));

    // R4
    drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !wr_n);

    // R7
    strobe_rise_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(astb_n) || $rose(dstb_n)) |-> ($past(wait_s) || (done && timeout)));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && !$past(wait_s)));

    // R3
    strobe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!astb_n || !dstb_n) |-> busy);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    // R11
    abort_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (astb_n && dstb_n && wr_n && !bus_oe));
endmodule

bind epp_host_master epp_host_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .astb_n    (astb_n),
    .dstb_n    (dstb_n),
    .wr_n      (wr_n),
    .bus_oe    (bus_oe),
    .wait_s    (wait_s)
);

// File: tb/test_epp_host_master.sv
`timescale 1ns/1ps
module test_epp_host_master;
    localparam int SETUP_CYC   = 8;
    localparam int STROBE_CYC  = 16;
    localparam int TIMEOUT_CYC = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       busy, done, timeout, astb_n, dstb_n, wr_n, bus_oe;
    logic [7:0] rd_data, bus_out;
    logic [7:0] bus_in = 8'h00;
    logic       wait_in = 1'b0;

    always #2.5 clk = ~clk;

    epp_host_master #(
        .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) i_epp_host_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .timeout(timeout),
        .rd_data(rd_data), .astb_n(astb_n), .dstb_n(dstb_n), .wr_n(wr_n),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .wait_in(wait_in)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_true(input string req, input string what, input bit ok,
                            input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct { int op; logic [7:0] data; bit tmo; logic [7:0] rd; } exp_t;
    typedef struct { bit addr; bit wrn; logic [7:0] b; } seen_t;
    exp_t  exp_q[$];
    seen_t per_q[$];
    exp_t  mon_e;
    seen_t mon_p;
    seen_t per_s;

    // Peripheral model controls
    int rise_dly = 0;
    int fall_dly = 0;
    bit hang_rise = 0;
    bit hang_fall = 0;
    logic [7:0] rd_val = 8'h00;
    int last_low = 0;
    int n_strobe = 0;
    int n_done = 0;

    // Peripheral model
    initial begin : periph
        int setup_cnt;
        bit s_wrn, s_oe;
        setup_cnt = 0;
        s_wrn = 1; s_oe = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                setup_cnt = 0;
            end else if (astb_n && dstb_n) begin
                if (!busy) setup_cnt = 0;
                else begin
                    setup_cnt++;
                    if (setup_cnt == 1) begin s_wrn = wr_n; s_oe = bus_oe; end
                end
            end else begin
                int low;
                int k;
                n_strobe++;
                chk("R4", "setup cycles before strobe", setup_cnt, SETUP_CYC);
                chk("R4", "wr_n stable through setup", int'(wr_n), int'(s_wrn));
                chk("R4", "bus_oe stable through setup", int'(bus_oe), int'(s_oe));
                per_s.addr = !astb_n; per_s.wrn = wr_n; per_s.b = bus_out;
                per_q.push_back(per_s);
                if (wr_n) bus_in = rd_val;
                low = 1;
                k = 0;
                forever begin
                    if (k == rise_dly && !hang_rise) wait_in = 1'b1;
                    @(negedge clk);
                    k++;
                    if (astb_n && dstb_n) break;
                    low++;
                end
                last_low = low;
                if (!hang_rise) begin
                    chk_true("R6", "strobe low width minimum", low >= STROBE_CYC, low, STROBE_CYC);
                    chk_true("R7", "strobe held until wait seen", low > rise_dly, low, rise_dly + 1);
                    chk("R8", "wr_n held after strobe rise", int'(wr_n), int'(per_s.wrn));
                    if (!per_s.wrn) chk("R8", "byte held after strobe rise",
                                         int'(bus_out), int'(per_s.b));
                    k = 0;
                    while (k < fall_dly) begin @(negedge clk); k++; end
                    while (hang_fall) @(negedge clk);
                    wait_in = 1'b0;
                    bus_in = ~rd_val;
                end
                setup_cnt = 0;
            end
        end
    end

    // Monitor / scoreboard
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    chk("R3", "unexpected done", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk("R8", "timeout flag at done", int'(timeout), int'(mon_e.tmo));
                    chk("R8", "busy low at done", int'(busy), 0);
                    if (per_q.size() == 0) begin
                        chk("R5", "bus cycle missing", 0, 1);
                    end else begin
                        mon_p = per_q.pop_front();
                        chk("R5", "strobe kind", int'(mon_p.addr), int'(mon_e.op == 0));
                        chk("R4", "wr_n during strobe", int'(mon_p.wrn), int'(mon_e.op == 2));
                        if (mon_e.op != 2)
                            chk("R4", "written byte", int'(mon_p.b), int'(mon_e.data));
                    end
                    if (mon_e.op == 2 && !mon_e.tmo)
                        chk("R9", "read byte", int'(rd_data), int'(mon_e.rd));
                    if (mon_e.tmo) begin
                        chk("R10", "strobes high after abort", int'(astb_n && dstb_n), 1);
                        chk("R11", "bus released after abort", int'(bus_oe), 0);
                        chk("R11", "wr_n high after abort", int'(wr_n), 1);
                    end
                end
            end
        end
    end

    task automatic issue(input int op, input logic [7:0] data, input bit tmo, input logic [7:0] rd);
        exp_t e;
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_wdata = data;
        e.op = op; e.data = data; e.tmo = tmo; e.rd = rd;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2", "busy after accept", int'(busy), 1);
    endtask

    task automatic finish_cmd();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int s0, d0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "astb_n in reset", int'(astb_n), 1);
        chk("R1", "dstb_n in reset", int'(dstb_n), 1);
        chk("R1", "wr_n in reset", int'(wr_n), 1);
        chk("R1", "bus_oe in reset", int'(bus_oe), 0);
        chk("R1", "busy/done/timeout in reset", int'({busy, done, timeout}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "idle after reset", int'({busy, done, timeout, bus_oe}), 0);

        // R6: address write with wait already answering -> exact width
        rise_dly = 0; fall_dly = 0;
        issue(0, 8'h5A, 0, 8'h00);
        finish_cmd();
        chk("R6", "exact strobe width", last_low, STROBE_CYC);

        // R7: slow wait response stretches the strobe
        rise_dly = 40;
        issue(1, 8'hC3, 0, 8'h00);
        finish_cmd();
        chk_true("R7", "stretched strobe", last_low > 40, last_low, 41);

        // R9: read
        rise_dly = 3; fall_dly = 5; rd_val = 8'h96;
        issue(2, 8'h00, 0, 8'h96);
        finish_cmd();

        // R9: write leaves rd_data untouched
        rise_dly = 0; fall_dly = 2;
        issue(1, 8'h11, 0, 8'h00);
        finish_cmd();
        chk("R9", "rd_data kept over write", int'(rd_data), 8'h96);

        rd_val = 8'h3C;
        issue(2, 8'h00, 0, 8'h3C);
        finish_cmd();

        // R3: command while busy is ignored
        s0 = n_strobe; d0 = n_done;
        issue(1, 8'h22, 0, 8'h00);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_wdata = 8'hEE;
        @(negedge clk);
        cmd_valid = 1'b0;
        finish_cmd();
        repeat (4) @(negedge clk);
        chk("R3", "one strobe for busy overlap", n_strobe - s0, 1);
        chk("R3", "one done for busy overlap", n_done - d0, 1);

        // R3: unused op code 3 is ignored
        s0 = n_strobe;
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_wdata = 8'h44;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", "op 3 gives no busy", int'(busy), 0);
        chk("R3", "op 3 gives no strobe", n_strobe - s0, 0);

        // R10: wait never rises
        hang_rise = 1;
        issue(1, 8'h77, 1, 8'h00);
        finish_cmd();
        chk("R10", "strobe low until timeout", last_low, TIMEOUT_CYC);
        hang_rise = 0;

        // R11: wait never falls
        hang_fall = 1;
        issue(0, 8'hA5, 1, 8'h00);
        finish_cmd();
        // R3: command while wait is high is ignored
        s0 = n_strobe;
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_wdata = 8'h99;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", "wait high blocks command", int'(busy), 0);
        chk("R3", "wait high gives no strobe", n_strobe - s0, 0);
        hang_fall = 0;
        repeat (6) @(negedge clk);

        // Recovery read after timeouts
        rise_dly = 1; fall_dly = 0; rd_val = 8'hE1;
        issue(2, 8'h00, 0, 8'hE1);
        finish_cmd();

        repeat (4) @(negedge clk);
        chk("R8", "all expected completions seen", exp_q.size(), 0);
        chk("R5", "all bus cycles accounted", per_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule